// File: doc/BRIEF.md
# Erase/Program Suspend-Resume Controller

This block pauses a running self-timed erase or program operation and continues it later. A start request loads a cycle counter that models the operation's duration, and BUSY is high while that counter runs. A decoded suspend command asks for a pause. Once a parameterised latency has elapsed, BUSY drops and SUS rises together. The count that remains at that edge is kept in a frozen copy.

A decoded resume command clears SUS, raises BUSY and reloads the frozen count. The operation therefore finishes after exactly as many busy cycles as it would have used without the pause. Suspend and resume have mutually exclusive acceptance conditions, so at most one of them can be accepted in any cycle. A power-loss input clears the operation, SUS and the saved count. After that, a later resume has nothing to continue and is rejected.

The block is fed by a command decoder. It reports `busy_o`, `sus_o`, the live or frozen remaining count, and a one-cycle completion pulse.

Top module: `susp_resume_ctrl`

## Requirements
- R1: During and right after reset, `busy_o`, `sus_o`, `done_o` are 0 and `remaining_o` is 0.
- R2: `start_i` with a nonzero `start_cycles_i` is taken only when `busy_o`=0 and `sus_o`=0. When taken, `busy_o` is 1 from the next edge for exactly `start_cycles_i` cycles. `done_o` is 1 for the single cycle in which `busy_o` first reads 0 again. In every other case `start_i` has no effect, and this includes a zero count.
- R3: `suspend_i` has no effect when `sus_o`=1, when `busy_o`=0, or while an earlier suspend is still waiting out its latency.
- R4: For an accepted suspend, sampled at edge E, `busy_o` falls and `sus_o` rises together on edge E+`SUSP_LAT`. Until then, `remaining_o` keeps counting down by one per cycle.
- R5: While `sus_o`=1, `remaining_o` holds the frozen count and does not change.
- R6: `resume_i` has no effect when `sus_o`=0 or `busy_o`=1.
- R7: An accepted resume clears `sus_o` and sets `busy_o` on the next edge, and `remaining_o` is reloaded with the frozen count. The total number of busy cycles equals the original `start_cycles_i`.
- R8: Suppose the operation reaches its final cycle on the same edge on which the suspend latency expires. Completion then wins: `busy_o` falls, `done_o` pulses and `sus_o` stays 0.
- R9: `power_loss_i` forces `busy_o`, `sus_o` and `remaining_o` to 0 on the next edge, and it overrides every command. A resume issued afterwards has no effect.
- R10: A suspend that arrives in the last busy cycle of an operation is ignored, and the operation completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a self-timed operation |
| start_cycles_i | input | CNT_W | Duration of the operation in cycles |
| suspend_i | input | 1 | Decoded suspend command, one cycle |
| resume_i | input | 1 | Decoded resume command, one cycle |
| power_loss_i | input | 1 | Power lost: abort and discard any suspended state |
| busy_o | output | 1 | Operation in progress |
| sus_o | output | 1 | Operation suspended |
| done_o | output | 1 | One-cycle pulse when an operation completes |
| remaining_o | output | CNT_W | Live remaining count, or the frozen count while suspended |

## Verification
Two events can land on the same edge: the operation timer reaching its last cycle, and the suspend latency expiring. The bench forces this by issuing a suspend when exactly `SUSP_LAT`+1 cycles remain. It then expects `busy_o` to fall with a `done_o` pulse and `sus_o` to stay low. A second case issues a suspend in the very last busy cycle and expects plain completion. A per-cycle reference built from the requirements feeds a scoreboard queue, and every sampled output cycle is compared against it.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DRAIN = 2'd2,  // suspend accepted, latency running
    PH_HELD  = 2'd3   // suspended
  } phase_t;
endpackage

// File: rtl/srs_op_timer.sv
module srs_op_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign last_o = run_i && (cnt_q == ONE);

  AST_RUN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q != '0); // R2
endmodule

// File: rtl/srs_lat_timer.sv
module srs_lat_timer #(
  parameter int SUSP_LAT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cancel_i,
  output logic pend_o,
  output logic expire_o
);
  localparam int LAT_W = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;
  localparam logic [LAT_W-1:0] LAT_INIT = LAT_W'(SUSP_LAT - 1);

  logic             pend_q;
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lat_q  <= '0;
    end else if (cancel_i) begin
      pend_q <= 1'b0;
      lat_q  <= '0;
    end else if (arm_i) begin
      pend_q <= 1'b1;
      lat_q  <= LAT_INIT;
    end else if (pend_q) begin
      if (lat_q == '0) pend_q <= 1'b0;
      else             lat_q  <= lat_q - LAT_W'(1);
    end
  end

  assign pend_o   = pend_q;
  assign expire_o = pend_q && (lat_q == '0);

  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |-> !pend_q); // R3
  AST_EXPIRE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !pend_q); // R4
endmodule

// File: rtl/srs_save_reg.sv
module srs_save_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] saved_o
);
  logic [CNT_W-1:0] saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      saved_q <= '0;
    else if (clear_i) saved_q <= '0;
    else if (cap_i)   saved_q <= val_i;
  end

  assign saved_o = saved_q;

  AST_SAVE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> val_i != '0); // R7
endmodule

// File: rtl/susp_resume_ctrl.sv
module susp_resume_ctrl
  import srs_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SUSP_LAT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_cycles_i,
  input  logic             suspend_i,
  input  logic             resume_i,
  input  logic             power_loss_i,
  output logic             busy_o,
  output logic             sus_o,
  output logic             done_o,
  output logic [CNT_W-1:0] remaining_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t           phase_q, phase_d;
  logic             running, fin, expire, lat_pend;
  logic             start_ok, sus_ok, res_ok, hold_ok;
  logic [CNT_W-1:0] cnt, saved, load_val;
  logic             done_q;

  assign running  = (phase_q == PH_RUN) || (phase_q == PH_DRAIN);
  assign start_ok = !power_loss_i && start_i && (phase_q == PH_IDLE) && (start_cycles_i != '0);
  assign sus_ok   = !power_loss_i && suspend_i && (phase_q == PH_RUN) && !fin;
  assign res_ok   = !power_loss_i && resume_i && (phase_q == PH_HELD);
  // completion has priority over latency expiry
  assign hold_ok  = !power_loss_i && (phase_q == PH_DRAIN) && expire && !fin;
  assign load_val = res_ok ? saved : start_cycles_i;

  srs_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (power_loss_i),
    .load_i     (start_ok || res_ok),
    .load_val_i (load_val),
    .run_i      (running),
    .cnt_o      (cnt),
    .last_o     (fin)
  );

  srs_lat_timer #(.SUSP_LAT(SUSP_LAT)) u_lat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (sus_ok),
    .cancel_i (power_loss_i || fin),
    .pend_o   (lat_pend),
    .expire_o (expire)
  );

  srs_save_reg #(.CNT_W(CNT_W)) u_save (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (power_loss_i || res_ok),
    .cap_i   (hold_ok),
    .val_i   (cnt - ONE),
    .saved_o (saved)
  );

  always_comb begin
    phase_d = phase_q;
    if (power_loss_i) phase_d = PH_IDLE;
    else begin
      unique case (phase_q)
        PH_IDLE:  if (start_ok) phase_d = PH_RUN;
        PH_RUN:   if (fin) phase_d = PH_IDLE;
                  else if (sus_ok) phase_d = PH_DRAIN;
        PH_DRAIN: if (fin) phase_d = PH_IDLE;
                  else if (hold_ok) phase_d = PH_HELD;
        PH_HELD:  if (res_ok) phase_d = PH_RUN;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= fin && !power_loss_i;
    end
  end

  assign busy_o      = running;
  assign sus_o       = (phase_q == PH_HELD);
  assign done_o      = done_q;
  assign remaining_o = sus_o ? saved : cnt;

  AST_DRAIN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DRAIN) == lat_pend); // R4
  AST_SUS_WITH_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sus_o) |-> $fell(busy_o)); // R4
  AST_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && sus_o)); // R6
  AST_HELD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sus_o && $past(sus_o) |-> $stable(remaining_o)); // R5
  AST_RESUME_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sus_o) && !$past(power_loss_i) |-> busy_o); // R7
  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !sus_o && $past(busy_o)); // R2
  AST_PWR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_loss_i |=> !busy_o && !sus_o && remaining_o == '0); // R9
  AST_IDLE_SUSPEND_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i && !busy_o && !sus_o |=> !sus_o); // R3
endmodule

// File: tb/susp_resume_ctrl_tb.sv
module susp_resume_ctrl_tb;
  localparam int CW  = 16;
  localparam int LAT = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni;
  logic          start_i, suspend_i, resume_i, power_loss_i;
  logic [CW-1:0] start_cycles_i;
  logic          busy_o, sus_o, done_o;
  logic [CW-1:0] remaining_o;

  susp_resume_ctrl #(.CNT_W(CW), .SUSP_LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_cycles_i(start_cycles_i),
    .suspend_i(suspend_i), .resume_i(resume_i), .power_loss_i(power_loss_i),
    .busy_o(busy_o), .sus_o(sus_o), .done_o(done_o), .remaining_o(remaining_o)
  );

  typedef struct {
    bit    busy;
    bit    sus;
    int    rem;
    bit    done;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    total = 0, bad = 0, busy_cnt = 0;
  bit    ended = 0;

  // reference state, derived from the requirements
  bit m_busy = 0, m_sus = 0;
  int m_rem = 0, m_lat = -1, m_saved = 0;

  task automatic chk(bit ok, string tag, string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic step(bit st, int cyc, bit su, bit re, bit pl, string tag);
    exp_t e;
    bit   fin, dn;
    @(negedge clk);
    start_i = st; start_cycles_i = CW'(cyc); suspend_i = su; resume_i = re; power_loss_i = pl;
    dn = 0;
    if (pl) begin
      m_busy = 0; m_sus = 0; m_rem = 0; m_lat = -1; m_saved = 0;
    end else begin
      fin = m_busy && (m_rem == 1);
      if (fin) begin
        m_busy = 0; m_rem = 0; m_lat = -1; dn = 1;
      end else if (m_busy && m_lat == 0) begin
        m_busy = 0; m_sus = 1; m_saved = m_rem - 1; m_rem = m_saved; m_lat = -1;
      end else if (m_busy) begin
        m_rem--;
        if (m_lat > 0) m_lat--;
        else if (su) m_lat = LAT - 1;
      end else if (m_sus) begin
        if (re) begin
          m_sus = 0; m_busy = 1; m_rem = m_saved; m_saved = 0;
        end
      end else if (st && cyc != 0) begin
        m_busy = 1; m_rem = cyc;
      end
    end
    e.busy = m_busy; e.sus = m_sus; e.rem = m_rem; e.done = dn; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  // monitor: compare each post-edge sample with the queued expectation
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (busy_o === 1'b1) busy_cnt++;
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if (busy_o !== e.busy || sus_o !== e.sus || done_o !== e.done || int'(remaining_o) != e.rem) begin
          bad++;
          $display("FAIL %s busy=%0b/%0b sus=%0b/%0b done=%0b/%0b rem=%0d/%0d (actual/expected)",
                   e.tag, busy_o, e.busy, sus_o, e.sus, done_o, e.done, remaining_o, e.rem);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; start_i = 0; start_cycles_i = '0; suspend_i = 0; resume_i = 0; power_loss_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy_o === 0 && sus_o === 0 && done_o === 0 && remaining_o == '0, "R1", "reset state");
    rst_ni = 1;
    @(posedge clk); #1;
    chk(busy_o === 0 && sus_o === 0 && done_o === 0 && remaining_o == '0, "R1", "after reset release");

    // idle commands ignored
    step(0, 0, 1, 0, 0, "R3 idle suspend");
    step(0, 0, 0, 1, 0, "R6 idle resume");
    step(1, 0, 0, 0, 0, "R2 zero count start");
    idle(2, "R3 R6 idle hold");

    // full suspend/resume of a 20-cycle operation
    busy_cnt = 0;
    step(1, 20, 0, 0, 0, "R2 start 20");
    idle(4, "R2 run");
    step(0, 0, 0, 1, 0, "R6 resume while busy");
    step(1, 7, 0, 0, 0, "R2 start while busy");
    step(0, 0, 1, 0, 0, "R4 suspend accepted");
    step(0, 0, 1, 0, 0, "R3 suspend while pending");
    idle(2, "R4 latency");
    step(0, 0, 0, 0, 0, "R4 expiry edge");
    idle(4, "R5 held");
    step(0, 0, 1, 0, 0, "R3 suspend while suspended");
    step(1, 9, 0, 0, 0, "R2 start while suspended");
    step(0, 0, 0, 1, 0, "R7 resume");
    idle(14, "R7 run to end");
    idle(2, "R7 after end");
    @(posedge clk); #2;
    chk(busy_cnt == 20, "R7", $sformatf("busy cycles %0d expected 20", busy_cnt));

    // suspend in the last busy cycle
    step(1, 3, 0, 0, 0, "R10 start 3");
    idle(2, "R10 run");
    step(0, 0, 1, 0, 0, "R10 suspend on last cycle");
    idle(3, "R10 after");

    // completion coincides with latency expiry
    step(1, 6, 0, 0, 0, "R8 start 6");
    step(0, 0, 0, 0, 0, "R8 run");
    step(0, 0, 1, 0, 0, "R8 suspend with LAT+1 left");
    idle(5, "R8 collision");

    // power loss while suspended, then resume rejected
    step(1, 30, 0, 0, 0, "R9 start 30");
    idle(3, "R9 run");
    step(0, 0, 1, 0, 0, "R9 suspend");
    idle(6, "R9 reach held");
    step(0, 0, 0, 0, 1, "R9 power loss held");
    step(0, 0, 0, 1, 0, "R9 resume after loss");
    idle(3, "R9 stays idle");

    // power loss while running, with commands in the same cycle
    step(1, 12, 0, 0, 0, "R9 start 12");
    idle(2, "R9 run");
    step(1, 5, 1, 1, 1, "R9 power loss busy");
    idle(2, "R9 idle after loss");

    idle(1, "R1 tail");
    repeat (3) @(posedge clk);
    #2;
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule